// File: doc/BRIEF.md
# Outbound Address Window Translator

This block holds four programmable outbound address windows and maps 64-bit request addresses onto 64-bit target addresses. A window is described by a start address, an end bound and a target address, each split into 32-bit halves, plus a control word with an enable bit and an extended-bound bit. Software-side logic programs the windows one 32-bit word at a time through a simple write port. Each request is compared against every enabled window in parallel. The lowest-numbered matching window supplies the translated address. A request that matches no window leaves the block unchanged and is flagged as a miss.

Windows are aligned to 64 KB. The end bound's upper half depends on the extended-bound bit. When the bit is clear, the upper half is the upper half of the start address, so a window cannot cross a 4 GB line. When the bit is set, the upper half comes from its own register. Programming software must set the bit whenever the upper half of (base + size − 1) exceeds the upper half of the base, even when the size is below 4 GB. A window whose computed end lies below its start matches nothing.

Top module: `ob_xlate_unit`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the field picked by `wr_sel` of window `wr_win`. The `wr_sel` codes are 0 lower base, 1 upper base, 2 lower bound, 3 upper bound, 4 lower target, 5 upper target and 6 control. In the control word, bit 0 is enable and bit 1 is extended-bound. A write is seen by requests presented from the next clock on. A request presented in the same cycle as the write sees the old contents.
- R2: The window start is {upper base, lower base} with the low 16 bits forced to zero. An address one below the start misses, and an address equal to the start hits.
- R3: When extended-bound is 0, the window end is {upper base, lower bound} with the low 16 bits forced to ones. An address equal to the end hits, and the next address misses.
- R4: When extended-bound is 1, the upper 32 bits of the end come from the upper bound register instead of the upper base.
- R5: A window whose enable bit is 0 never matches.
- R6: A window whose end lies below its start never matches. For example, base 0x0_F000_0000 with lower bound 0x1000_0000 and extended-bound 0 matches nothing. The same window with extended-bound 1 and upper bound 1 covers up to 0x1_1000_FFFF.
- R7: On a hit, `rsp_addr` equals target + (request − start), where the target's low 16 bits are forced to zero, and `rsp_win` gives the window index.
- R8: When several windows match, the lowest-numbered one is used.
- R9: On no match, `rsp_miss` is 1, `rsp_hit` is 0, `rsp_win` is 0 and `rsp_addr` equals the request address.
- R10: A request with `req_valid` high gives `rsp_valid` high with its result exactly one clock later. A cycle without a request gives `rsp_valid` low one clock later.
- R11: After reset, all windows are disabled and all registers are zero. `rsp_valid`, `rsp_hit` and `rsp_miss` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 2 | Window index of the write |
| wr_sel | input | 3 | Field code of the write |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | A window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_win | output | 2 | Index of the matching window |
| rsp_addr | output | 64 | Translated address or unchanged request address |

## Verification
A wrong stored field or a wrong end bound shows up in the result cycle that follows a request near that window's edge. Such a request either flips between hit and miss or carries an address with the wrong offset. The bench therefore probes each window edge one address on either side. It also checks the 4 GB crossing case under both settings of the extended-bound bit. A priority fault appears only where windows overlap, so one address is placed in an overlap and one just outside it. A latency or write-timing fault shows up as a result one cycle early or late, or as a write that a request in the same cycle already sees.

// File: rtl/oatu_pkg.sv
package oatu_pkg;

    localparam int HALF_W = 32;

    typedef enum logic [2:0] {
        SEL_LBASE  = 3'd0,
        SEL_UBASE  = 3'd1,
        SEL_LBOUND = 3'd2,
        SEL_UBOUND = 3'd3,
        SEL_LTGT   = 3'd4,
        SEL_UTGT   = 3'd5,
        SEL_CTRL   = 3'd6
    } field_sel_e;

    typedef struct packed {
        logic [HALF_W-1:0] lbase;
        logic [HALF_W-1:0] ubase;
        logic [HALF_W-1:0] lbound;
        logic [HALF_W-1:0] ubound;
        logic [HALF_W-1:0] ltgt;
        logic [HALF_W-1:0] utgt;
        logic              en;
        logic              ext;
    } win_cfg_t;

endpackage

// File: rtl/oatu_win_regs.sv
module oatu_win_regs
    import oatu_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W = $clog2(NUM_WIN)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_win,
    input  logic [2:0]                    wr_sel,
    input  logic [HALF_W-1:0]             wr_data,
    output win_cfg_t [NUM_WIN-1:0]        cfg
);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[i] <= '0;
            end else if (wr_en && (wr_win == IDX_W'(i))) begin
                unique case (field_sel_e'(wr_sel))
                    SEL_LBASE:  cfg[i].lbase  <= wr_data;
                    SEL_UBASE:  cfg[i].ubase  <= wr_data;
                    SEL_LBOUND: cfg[i].lbound <= wr_data;
                    SEL_UBOUND: cfg[i].ubound <= wr_data;
                    SEL_LTGT:   cfg[i].ltgt   <= wr_data;
                    SEL_UTGT:   cfg[i].utgt   <= wr_data;
                    SEL_CTRL: begin
                        cfg[i].en  <= wr_data[0];
                        cfg[i].ext <= wr_data[1];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/oatu_win_match.sv
module oatu_win_match
    import oatu_pkg::*;
#(
    parameter int GRAN_BITS = 16,
    localparam logic [HALF_W-1:0] LOW_MASK = HALF_W'((64'd1 << GRAN_BITS) - 64'd1)
) (
    input  win_cfg_t          cfg,
    input  logic [63:0]       addr,
    output logic              hit,
    output logic [63:0]       xlat
);

    logic [63:0] start_a;
    logic [63:0] end_a;
    logic [63:0] tgt_a;
    logic [HALF_W-1:0] end_hi;

    always_comb begin
        end_hi  = cfg.ext ? cfg.ubound : cfg.ubase;
        start_a = {cfg.ubase, cfg.lbase & ~LOW_MASK};
        end_a   = {end_hi, cfg.lbound | LOW_MASK};
        tgt_a   = {cfg.utgt, cfg.ltgt & ~LOW_MASK};
        hit     = cfg.en && (addr >= start_a) && (addr <= end_a);
        xlat    = tgt_a + (addr - start_a);
    end

endmodule

// File: rtl/oatu_pick.sv
module oatu_pick #(
    parameter int NUM_WIN = 4,
    localparam int IDX_W = $clog2(NUM_WIN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_WIN-1:0]      hits,
    input  logic [NUM_WIN-1:0]      ens,
    input  logic [63:0]             xlats [NUM_WIN],
    input  logic                    req_valid,
    input  logic [63:0]             req_addr,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic                    rsp_miss,
    output logic [IDX_W-1:0]        rsp_win,
    output logic [63:0]             rsp_addr
);

    logic [IDX_W-1:0]   sel;
    logic               found;
    logic [NUM_WIN-1:0] grant;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                sel   = IDX_W'(i);
                found = 1'b1;
            end
        end
        grant = found ? (NUM_WIN'(1) << sel) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_win   <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit  <= found;
                rsp_miss <= !found;
                rsp_win  <= found ? sel : '0;
                rsp_addr <= found ? xlats[sel] : req_addr;
            end
        end
    end

    a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_chk
        a_r5_grant_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> ens[i]);
        if (i > 0) begin : g_lo
            a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
                grant[i] |-> (hits[i-1:0] == '0));
        end
    end

endmodule

// File: rtl/ob_xlate_unit.sv
module ob_xlate_unit
    import oatu_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int GRAN_BITS = 16,
    localparam int IDX_W = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_win,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [IDX_W-1:0]  rsp_win,
    output logic [63:0]       rsp_addr
);

    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     hits;
    logic [NUM_WIN-1:0]     ens;
    logic [63:0]            xlats [NUM_WIN];

    oatu_win_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_win  (wr_win),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        assign ens[i] = cfg[i].en;
        oatu_win_match #(.GRAN_BITS(GRAN_BITS)) u_match (
            .cfg  (cfg[i]),
            .addr (req_addr),
            .hit  (hits[i]),
            .xlat (xlats[i])
        );
    end

    oatu_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .hits      (hits),
        .ens       (ens),
        .xlats     (xlats),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_win   (rsp_win),
        .rsp_addr  (rsp_addr)
    );

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r9_miss_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (hits == '0)) |=> (rsp_miss && !rsp_hit && rsp_addr == $past(req_addr)));

    a_r9_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

endmodule

// File: tb/ob_xlate_unit_tb.sv
module ob_xlate_unit_tb;

    typedef struct {
        logic        hit;
        logic [1:0]  win;
        logic [63:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_win = '0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [1:0]  rsp_win;
    logic [63:0] rsp_addr;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    ob_xlate_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win),
        .wr_sel(wr_sel), .wr_data(wr_data), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_win(rsp_win), .rsp_addr(rsp_addr)
    );

    // Monitor: pops one expected item per valid result
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R10: unexpected rsp_valid, actual=1 expected=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rsp_hit !== e.hit || rsp_miss !== !e.hit ||
                    rsp_win !== e.win || rsp_addr !== e.addr) begin
                    errors++;
                    $display("FAIL %s: actual hit=%0b miss=%0b win=%0d addr=%h expected hit=%0b win=%0d addr=%h",
                             e.tag, rsp_hit, rsp_miss, rsp_win, rsp_addr,
                             e.hit, e.win, e.addr);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] w, input logic [2:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_win = w; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [63:0] a, input logic h, input logic [1:0] w,
                        input logic [63:0] x, input string tag);
        exp_t e;
        e.hit = h; e.win = w; e.addr = x; e.tag = tag;
        q.push_back(e);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(rsp_valid === 1'b0 && rsp_hit === 1'b0 && rsp_miss === 1'b0,
              $sformatf("R11: reset outputs actual v=%0b h=%0b m=%0b expected 0 0 0",
                        rsp_valid, rsp_hit, rsp_miss));
        rst_n = 1'b1;
        @(negedge clk);
        send(64'h0000_0000_8000_0010, 1'b0, 2'd0, 64'h0000_0000_8000_0010, "R11 all windows off");

        // window 0: 0x8000_0000..0x8FFF_FFFF -> 0x2_0000_0000
        wr(2'd0, 3'd0, 32'h8000_1234);
        wr(2'd0, 3'd1, 32'h0);
        wr(2'd0, 3'd2, 32'h8FFF_0000);
        wr(2'd0, 3'd4, 32'h0000_ABCD);
        wr(2'd0, 3'd5, 32'h2);
        // R1: request in the write cycle sees old enable
        q.push_back('{1'b0, 2'd0, 64'h0000_0000_8000_0010, "R1 same-cycle write unseen"});
        wr_en = 1'b1; wr_win = 2'd0; wr_sel = 3'd6; wr_data = 32'h1;
        req_valid = 1'b1; req_addr = 64'h0000_0000_8000_0010;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        send(64'h0000_0000_8000_0010, 1'b1, 2'd0, 64'h0000_0002_0000_0010, "R1 write seen next cycle");
        @(negedge clk);
        check(rsp_valid === 1'b0, $sformatf("R10: idle gives rsp_valid actual=%0b expected=0", rsp_valid));

        send(64'h0000_0000_7FFF_FFFF, 1'b0, 2'd0, 64'h0000_0000_7FFF_FFFF, "R2 below start");
        send(64'h0000_0000_8000_0000, 1'b1, 2'd0, 64'h0000_0002_0000_0000, "R2 at start");
        send(64'h0000_0000_8FFF_FFFF, 1'b1, 2'd0, 64'h0000_0002_0FFF_FFFF, "R3 at end");
        send(64'h0000_0000_9000_0000, 1'b0, 2'd0, 64'h0000_0000_9000_0000, "R3 past end");
        send(64'h0000_0001_8000_0000, 1'b0, 2'd0, 64'h0000_0001_8000_0000, "R9 upper half differs");

        // window 1: crosses 4 GB line
        wr(2'd1, 3'd0, 32'hF000_0000);
        wr(2'd1, 3'd2, 32'h1000_0000);
        wr(2'd1, 3'd3, 32'h1);
        wr(2'd1, 3'd5, 32'h10);
        wr(2'd1, 3'd6, 32'h1);
        send(64'h0000_0000_F000_0000, 1'b0, 2'd0, 64'h0000_0000_F000_0000, "R6 end below start");
        send(64'h0000_0000_F800_0000, 1'b0, 2'd0, 64'h0000_0000_F800_0000, "R6 inside malformed");
        wr(2'd1, 3'd6, 32'h3);
        send(64'h0000_0000_F800_0000, 1'b1, 2'd1, 64'h0000_0010_0800_0000, "R4 extended hit");
        send(64'h0000_0001_1000_FFFF, 1'b1, 2'd1, 64'h0000_0010_2000_FFFF, "R4 extended end");
        send(64'h0000_0001_1001_0000, 1'b0, 2'd0, 64'h0000_0001_1001_0000, "R4 past extended end");

        // window 2 overlaps window 0
        wr(2'd2, 3'd0, 32'h8800_0000);
        wr(2'd2, 3'd2, 32'h9FFF_0000);
        wr(2'd2, 3'd5, 32'h3);
        wr(2'd2, 3'd6, 32'h1);
        send(64'h0000_0000_8800_0000, 1'b1, 2'd0, 64'h0000_0002_0800_0000, "R8 overlap lowest wins");
        send(64'h0000_0000_9800_0000, 1'b1, 2'd2, 64'h0000_0003_1000_0000, "R7 offset translation");
        wr(2'd0, 3'd6, 32'h0);
        send(64'h0000_0000_8800_0000, 1'b1, 2'd2, 64'h0000_0003_0000_0000, "R5 disabled skipped");
        send(64'h0000_0000_8000_0000, 1'b0, 2'd0, 64'h0000_0000_8000_0000, "R5 disabled no match");

        // window 3: high upper base, flag clear
        wr(2'd3, 3'd1, 32'h0000_ABCD);
        wr(2'd3, 3'd2, 32'hFFFF_0000);
        wr(2'd3, 3'd4, 32'h0000_FFFF);
        wr(2'd3, 3'd6, 32'h1);
        send(64'h0000_ABCD_1234_5678, 1'b1, 2'd3, 64'h0000_0000_1234_5678, "R7 target low bits forced");
        send(64'h0000_ABCE_0000_0000, 1'b0, 2'd0, 64'h0000_ABCE_0000_0000, "R3 end upper from base");

        repeat (3) @(negedge clk);
        check(q.size() == 0, $sformatf("R10: results outstanding actual=%0d expected=0", q.size()));
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10: watchdog expired actual=%0d cycles expected=done", cycles);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule